// File: doc/BRIEF.md
# Multi-width up/down universal counter

This block is a general-purpose event counter with a 10-bit register whose active span can be narrowed at run time to 8, 6 or 4 bits. It counts up or down, one step per rising edge of whichever of eight level inputs is currently selected. Six of those inputs carry divided system clocks and two carry external event pins, so the same counter serves as a timer or as an event counter. Software can overwrite the count at any time with a parallel load.

A compare value is checked against each newly produced count. The comparison covers either every bit of the register or only the bits of the active span. A match raises a one-cycle match request. A separate one-cycle request marks the moment the count becomes zero. A pulse-width output is set high by a wrap or a load and driven low by a match, which makes the compare value the duty-cycle threshold of a period set by the span.

Top module: `ucnt_top`

## Requirements
- R1: `src_sel` selects one of the `src_lvl` inputs (indices 6 and 7 are the event pins). The count takes one step on the clock edge where the selected input is first sampled high after being sampled low. A level held high gives no further steps, and unselected inputs have no effect on the count.
- R2: `span_sel` sets the active width: 0 selects 4 bits, 1 selects 6, 2 selects 8 and 3 selects 10. From the edge after any change, every count bit above the active width reads zero.
- R3: When `dir_down` is 0, each step adds one, and the count wraps from the all-ones value of the active width to 0.
- R4: When `dir_down` is 1, each step subtracts one, and the count wraps from 0 to the all-ones value of the active width.
- R5: A high `load_stb` puts `load_val`, truncated to the active width, into the count on the next edge. A load takes priority over a step in the same cycle.
- R6: When `cmp_full` is 1, all 10 bits of a new count are compared with `cmp_val`. When it is 0, only the bits of the active width are compared. The comparison is made only on a cycle in which the count is stepped or loaded.
- R7: `irq_match` is high for exactly the cycle in which a matching new count first appears on `count`.
- R8: `irq_zero` is high for one cycle when `count` changes from a nonzero value to zero, whatever the cause. It is not raised again while the count stays at zero.
- R9: `pwm_out` goes high after a wrap or a load and goes low after a match. A match wins when both occur in the same cycle. Otherwise `pwm_out` holds its value.
- R10: While `rst_n` is low, `count` is 0 and `irq_match`, `irq_zero` and `pwm_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| src_lvl | input | 8 | Candidate count sources, already synchronised; 6 and 7 are event pins |
| src_sel | input | 3 | Index of the source that drives the count |
| span_sel | input | 2 | Active width code (4/6/8/10 bits) |
| dir_down | input | 1 | 1 counts down, 0 counts up |
| load_stb | input | 1 | Parallel load request |
| load_val | input | 10 | Value written by a load |
| cmp_val | input | 10 | Compare threshold |
| cmp_full | input | 1 | 1 compares all bits, 0 compares the active width only |
| count | output | 10 | Current count |
| irq_match | output | 1 | One-cycle compare match request |
| irq_zero | output | 1 | One-cycle reached-zero request |
| pwm_out | output | 1 | Pulse-width output |

## Verification
The bench builds the block with its default parameters: a 10-bit register and eight sources. With these values the four span codes map to 4, 6, 8 and 10 bits, so every width's wrap point can be reached in a few steps when counting starts from a loaded value next to it. The vector table places compare values whose upper bits lie outside a narrow span, so full and limited comparisons give different results on the same count. Directed tests then drive an event pin on index 6, hold a level high, change the span over a wide value, and send a load and a step in the same cycle.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

    // Active-width codes; the numeric order matters: each step adds two bits.
    typedef enum logic [1:0] {
        SPAN_NARROW = 2'd0,
        SPAN_LOW    = 2'd1,
        SPAN_MID    = 2'd2,
        SPAN_WIDE   = 2'd3
    } span_e;

    // Number of live bits for a span code on a register of cnt_w bits.
    function automatic int span_bits(input logic [1:0] code, input int cnt_w);
        return cnt_w - 2 * (3 - int'(code));
    endfunction

endpackage

// File: rtl/ucnt_tick.sv
module ucnt_tick #(
    parameter int NSRC  = 8,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_lvl_i,
    input  logic [SEL_W-1:0] src_sel_i,
    output logic             tick_o
);

    typedef struct packed {
        logic prev;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     lvl;

    always_comb begin
        lvl       = src_lvl_i[src_sel_i];
        st_d      = st_q;
        st_d.prev = lvl;
        tick_o    = lvl & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: a source that stays selected cannot give two steps back to back
    a_r1_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !(tick_o && (src_sel_i == $past(src_sel_i))));

endmodule

// File: rtl/ucnt_core.sv
module ucnt_core
    import ucnt_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [1:0]       span_i,
    input  logic             down_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] nxt_o,
    output logic [CNT_W-1:0] mask_o,
    output logic             upd_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cur;
    int               live;

    always_comb begin
        live = span_bits(span_i, CNT_W);
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (i < live);
        end
        cur    = st_q.cnt & mask;
        st_d   = st_q;
        upd_o  = 1'b0;
        wrap_o = 1'b0;
        st_d.cnt = cur;
        if (load_i) begin
            st_d.cnt = load_val_i & mask;
            upd_o    = 1'b1;
        end else if (tick_i) begin
            upd_o = 1'b1;
            if (down_i) begin
                wrap_o   = (cur == '0);
                st_d.cnt = (cur - 1'b1) & mask;
            end else begin
                wrap_o   = (cur == mask);
                st_d.cnt = (cur + 1'b1) & mask;
            end
        end
        nxt_o  = st_d.cnt;
        mask_o = mask;
        cnt_o  = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: nothing survives above the span that was active one edge earlier
    a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cnt_o & ~$past(mask)) == '0));

    // R3: upward step
    a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && !down_i) |=>
            (cnt_o == (($past(cnt_o) + 1'b1) & $past(mask))));

    // R4: downward step
    a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && down_i) |=>
            (cnt_o == (($past(cnt_o) - 1'b1) & $past(mask))));

    // R5: load wins over a step
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == ($past(load_val_i) & $past(mask))));

endmodule

// File: rtl/ucnt_evt.sv
module ucnt_evt #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] nxt_i,
    input  logic [CNT_W-1:0] mask_i,
    input  logic             upd_i,
    input  logic             wrap_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             cmp_full_i,
    output logic             irq_match_o,
    output logic             irq_zero_o,
    output logic             pwm_o
);

    typedef struct packed {
        logic match;
        logic zero;
        logic pwm;
    } evt_st_t;

    evt_st_t          st_d, st_q;
    logic [CNT_W-1:0] cmp_eff;
    logic             hit;

    always_comb begin
        cmp_eff    = cmp_full_i ? cmp_i : (cmp_i & mask_i);
        hit        = upd_i && (nxt_i == cmp_eff);
        st_d       = st_q;
        st_d.match = hit;
        st_d.zero  = (nxt_i == '0) && (cnt_i != '0);
        if (hit)                          st_d.pwm = 1'b0;
        else if (load_i || (upd_i && wrap_i)) st_d.pwm = 1'b1;
        irq_match_o = st_q.match;
        irq_zero_o  = st_q.zero;
        pwm_o       = st_q.pwm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a zero request is only raised while the count shows zero
    a_r8_zero_shows_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_zero_o |-> (cnt_i == '0));

    // R8: never two zero requests in a row
    a_r8_zero_once: assert property (@(posedge clk) disable iff (!rst_n)
        irq_zero_o |=> !irq_zero_o);

    // R9: a match leaves the pulse output low
    a_r9_match_low: assert property (@(posedge clk) disable iff (!rst_n)
        irq_match_o |-> !pwm_o);

    // R9: the pulse output only rises after a wrap or a load
    a_r9_pwm_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> $past(load_i || (upd_i && wrap_i)));

endmodule

// File: rtl/ucnt_top.sv
module ucnt_top (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  src_lvl,
    input  logic [2:0]  src_sel,
    input  logic [1:0]  span_sel,
    input  logic        dir_down,
    input  logic        load_stb,
    input  logic [9:0]  load_val,
    input  logic [9:0]  cmp_val,
    input  logic        cmp_full,
    output logic [9:0]  count,
    output logic        irq_match,
    output logic        irq_zero,
    output logic        pwm_out
);

    localparam int CNT_W = 10;
    localparam int NSRC  = 8;

    logic             tick;
    logic [CNT_W-1:0] cnt, nxt, mask;
    logic             upd, wrap;

    ucnt_tick #(.NSRC(NSRC)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lvl_i (src_lvl),
        .src_sel_i (src_sel),
        .tick_o    (tick)
    );

    ucnt_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (load_stb),
        .load_val_i (load_val),
        .span_i     (span_sel),
        .down_i     (dir_down),
        .cnt_o      (cnt),
        .nxt_o      (nxt),
        .mask_o     (mask),
        .upd_o      (upd),
        .wrap_o     (wrap)
    );

    ucnt_evt #(.CNT_W(CNT_W)) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_i       (cnt),
        .nxt_i       (nxt),
        .mask_i      (mask),
        .upd_i       (upd),
        .wrap_i      (wrap),
        .load_i      (load_stb),
        .cmp_i       (cmp_val),
        .cmp_full_i  (cmp_full),
        .irq_match_o (irq_match),
        .irq_zero_o  (irq_zero),
        .pwm_o       (pwm_out)
    );

    assign count = cnt;

    // R10: outputs quiet while reset is held
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (count == '0 && !irq_match && !irq_zero && !pwm_out));

endmodule

// File: tb/ucnt_top_tb_top.sv
module ucnt_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] src_lvl;
    logic [2:0] src_sel;
    logic [1:0] span_sel;
    logic       dir_down;
    logic       load_stb;
    logic [9:0] load_val;
    logic [9:0] cmp_val;
    logic       cmp_full;
    logic [9:0] count;
    logic       irq_match, irq_zero, pwm_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ucnt_top dut_i (
        .clk (clk), .rst_n (rst_n), .src_lvl (src_lvl), .src_sel (src_sel),
        .span_sel (span_sel), .dir_down (dir_down), .load_stb (load_stb),
        .load_val (load_val), .cmp_val (cmp_val), .cmp_full (cmp_full),
        .count (count), .irq_match (irq_match), .irq_zero (irq_zero),
        .pwm_out (pwm_out)
    );

    // Row: span[39:38] down[37] full[36] cmp[35:26] ld[25] ldv[24:15]
    //      steps[14:11] exp_count[10:1] exp_pwm[0]
    localparam logic [39:0] VEC [0:9] = '{
        {2'd3, 1'b0, 1'b1, 10'd500,  1'b1, 10'd5,     4'd3, 10'd8,     1'b1}, // R3 R5
        {2'd3, 1'b1, 1'b1, 10'd500,  1'b1, 10'd2,     4'd3, 10'h3FF,   1'b1}, // R4 R9
        {2'd0, 1'b0, 1'b0, 10'h3F1,  1'b1, 10'hE,     4'd3, 10'h1,     1'b0}, // R2 R6 R9
        {2'd1, 1'b1, 1'b1, 10'h03E,  1'b1, 10'h1,     4'd3, 10'h3E,    1'b0}, // R4 R6
        {2'd1, 1'b1, 1'b1, 10'h23E,  1'b1, 10'h1,     4'd3, 10'h3E,    1'b1}, // R6 full miss
        {2'd1, 1'b1, 1'b0, 10'h23E,  1'b1, 10'h1,     4'd3, 10'h3E,    1'b0}, // R6 limited hit
        {2'd2, 1'b0, 1'b1, 10'h3FF,  1'b1, 10'hFE,    4'd2, 10'h0,     1'b1}, // R3 8-bit wrap
        {2'd2, 1'b0, 1'b1, 10'h005,  1'b0, 10'h0,     4'd5, 10'h5,     1'b0}, // R9 match clears
        {2'd3, 1'b0, 1'b1, 10'h100,  1'b1, 10'h3FE,   4'd2, 10'h0,     1'b1}, // R3 10-bit wrap
        {2'd0, 1'b0, 1'b1, 10'h000,  1'b1, 10'h2AB,   4'd0, 10'hB,     1'b1}  // R5 truncation
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rise(input int idx);
        src_lvl[idx] = 1'b1;
        @(negedge clk);
    endtask

    task automatic fall(input int idx);
        src_lvl[idx] = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_load(input logic [9:0] v);
        load_val = v;
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; src_lvl = '0; src_sel = 3'd0; span_sel = 2'd3;
        dir_down = 1'b0; load_stb = 1'b0; load_val = '0; cmp_val = 10'd500;
        cmp_full = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 count", count, 0);
        chk("R10 irqs", {irq_match, irq_zero, pwm_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 R6 R9
        for (int r = 0; r < 10; r++) begin
            span_sel = VEC[r][39:38];
            dir_down = VEC[r][37];
            cmp_full = VEC[r][36];
            cmp_val  = VEC[r][35:26];
            if (VEC[r][25]) do_load(VEC[r][24:15]);
            else            @(negedge clk);
            for (int s = 0; s < int'(VEC[r][14:11]); s++) begin
                rise(0);
                fall(0);
            end
            checks++;
            if (count !== VEC[r][10:1] || pwm_out !== VEC[r][0]) begin
                errors++;
                $display("FAIL table row %0d (R2 R3 R4 R5 R6 R9): actual %0h/%0b expected %0h/%0b",
                         r, count, pwm_out, VEC[r][10:1], VEC[r][0]);
            end
        end

        // R1: select event pin 6; source 0 is then ignored
        src_sel = 3'd6;
        @(negedge clk);
        rise(0);
        fall(0);
        chk("R1 unselected ignored", count, 10'hB);
        rise(6);
        chk("R1 event pin step", count, 10'hC);
        repeat (3) @(negedge clk);
        chk("R1 held level one step", count, 10'hC);
        fall(6);

        // R8 R4: count down through zero
        span_sel = 2'd3; dir_down = 1'b1; cmp_full = 1'b1; cmp_val = 10'h3FD;
        do_load(10'd2);
        rise(6); fall(6);
        chk("R4 count 1", count, 1);
        rise(6);
        chk("R8 zero request", irq_zero, 1);
        fall(6);
        chk("R8 zero request drops", irq_zero, 0);
        rise(6);
        chk("R4 wrap to all ones", count, 10'h3FF);
        chk("R9 wrap sets pwm", pwm_out, 1);
        fall(6);
        rise(6); fall(6);
        rise(6);
        chk("R7 match request", irq_match, 1);
        chk("R9 match clears pwm", pwm_out, 0);
        fall(6);
        chk("R7 match one cycle", irq_match, 0);

        // R5 R8: load of zero from nonzero raises the zero request once
        do_load(10'd0);
        chk("R8 zero by load", irq_zero, 1);
        chk("R9 load sets pwm", pwm_out, 1);
        do_load(10'd0);
        chk("R8 no repeat at zero", irq_zero, 0);

        // R5: load and step in the same cycle
        dir_down = 1'b0;
        src_lvl[6] = 1'b1;
        do_load(10'h010);
        chk("R5 load beats step", count, 10'h010);
        fall(6);

        // R2: narrowing the span clears upper bits
        do_load(10'h1C7);
        span_sel = 2'd1;
        @(negedge clk);
        chk("R2 narrowed span", count, 10'h07);

        finish_run();
    end

endmodule